// File: doc/BRIEF.md
# Receive Byte FIFO with Receiver Status

This block sits between a serial receiver and a CPU register interface. The receiver hands over one assembled byte at a time. The block stores up to three bytes, and the CPU reads them back oldest first. Each accepted read advances the read pointer on its own.

Next to the storage, the block keeps the receive status:
- a receiver-enable bit;
- a software-only acknowledge-enable bit;
- a sticky frame-done flag;
- sticky CRC, alignment and abort/collision error flags;
- an overrun flag that only software can clear.

The line logic reports frame end and error conditions on plain pulse inputs. Hardware drops the receiver-enable bit at frame end, and also on any error. Writing the enable bit as 1 flushes the storage and clears the done and error flags.

The byte input uses valid/ready, but `in_ready` is advisory. The receiver cannot stall its serial line, so it presents a byte whenever one is assembled, whatever the value of `in_ready`. A byte offered while storage is full and no read is accepted is dropped and raises overrun.

The byte output uses valid/ready. A read is accepted on a cycle where `out_valid` and `out_ready` are both high and the storage actually holds a byte. `out_valid` is the not-empty status, and it is registered. For one cycle after the last byte is read it still shows 1. A read in that cycle is ignored.

Top module: `rx_fifo_stat`

## Requirements
- R1: Storage holds exactly 3 bytes. `out_data` shows the oldest stored byte whenever storage is not empty, and each accepted read removes that byte.
- R2: `out_valid` (not-empty) is 0 after reset. At each clock edge it takes whether storage held any byte before that edge, so it reflects a push or read one clock late.
- R3: A read is accepted only when `out_valid`, `out_ready` and actual storage occupancy are all true. A read in the stale cycle after emptying changes nothing.
- R4: A control write (`cfg_wr`=1) with `cfg_rx_en`=1 sets the enable bit, empties storage, and clears the done, CRC, alignment and abort flags. The overrun flag is unaffected. A control write with `cfg_rx_en`=0 clears the enable bit.
- R5: Bytes are accepted only while the enable bit is 1 and no control write is in progress. `in_ready` equals enable AND (fewer than 3 bytes stored).
- R6: A byte offered while enabled, with 3 bytes stored and no accepted read, is discarded and sets overrun. The stored bytes are kept. Overrun stays set until `ovr_clr`; a new overrun in the same cycle as `ovr_clr` wins.
- R7: With 3 bytes stored, a byte offered in the same cycle as an accepted read is stored (read first) and raises no overrun.
- R8: `frame_end` while enabled sets done only if no error input and no overrun occur in that same cycle. `err_crc`, `err_align` and `err_abort` while enabled set their own sticky flags.
- R9: While enabled and without a control write, `frame_end`, any error input or an overrun clears the enable bit at that edge.
- R10: The acknowledge-enable bit changes only on a control write, taking `cfg_ack_en`.
- R11: In a control-write cycle, offered bytes and line events are ignored.
- R12: After reset, the enable bit, the acknowledge-enable bit and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Receiver presents an assembled byte |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Advisory: space exists and receiver enabled |
| out_valid | output | 1 | Registered not-empty status |
| out_data | output | 8 | Oldest stored byte |
| out_ready | input | 1 | CPU reads the oldest byte |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_rx_en | input | 1 | Enable value written |
| cfg_ack_en | input | 1 | Acknowledge-enable value written |
| ovr_clr | input | 1 | Software clear of overrun |
| frame_end | input | 1 | Line logic: frame ended |
| err_crc | input | 1 | Line logic: CRC mismatch |
| err_align | input | 1 | Line logic: alignment error |
| err_abort | input | 1 | Line logic: abort or collision |
| st_rx_en | output | 1 | Receiver enable bit |
| st_ack_en | output | 1 | Acknowledge enable bit |
| st_done | output | 1 | Frame completed cleanly |
| st_crc | output | 1 | CRC error flag |
| st_align | output | 1 | Alignment error flag |
| st_abort | output | 1 | Abort/collision flag |
| st_ovr | output | 1 | Overrun flag |

## Verification
The hardest cases to reach from the ports are overrun and the full-with-read case.
- Overrun needs the storage full and the receiver still enabled. A byte must then arrive without an accepted read.
- The read-first case needs the same full state, with the read landing in the very cycle the fourth byte arrives.

Directed phases build the full state by pushing three bytes with reads held off, then fire each case. A follow-up pair of reads covers the stale not-empty cycle. A long biased random phase then mixes enable writes, errors and reads against a queue-based model compared every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_SLOTS = 3;

  typedef struct packed {
    logic ovr;
    logic abort;
    logic align;
    logic crc;
    logic done;
  } rx_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic                           pop,
  input  logic [W-1:0]                   wdata,
  output logic [W-1:0]                   rdata,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [IW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
    if (p == IW'(DEPTH-1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= step_ptr(wr_ptr_q);
      if (pop)  rd_ptr_q <= step_ptr(rd_ptr_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!flush && push && wr_ptr_q == IW'(g)) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[rd_ptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  logic      cfg_rx_en,
  input  logic      cfg_ack_en,
  input  logic      ovr_clr,
  input  logic      frame_end,
  input  logic      err_crc,
  input  logic      err_align,
  input  logic      err_abort,
  input  logic      overrun_evt,
  output logic      rx_en,
  output logic      ack_en,
  output rx_flags_t flags
);
  logic      en_q, ack_q;
  rx_flags_t fl_q;
  logic      live, any_err, stop;

  assign live    = en_q && !cfg_wr;
  assign any_err = err_crc || err_align || err_abort || overrun_evt;
  assign stop    = live && (frame_end || any_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ack_q <= 1'b0;
    end else if (cfg_wr) begin
      en_q  <= cfg_rx_en;
      ack_q <= cfg_ack_en;
    end else if (stop) begin
      en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q <= '0;
    end else begin
      if (cfg_wr && cfg_rx_en) begin
        fl_q.done  <= 1'b0;
        fl_q.crc   <= 1'b0;
        fl_q.align <= 1'b0;
        fl_q.abort <= 1'b0;
      end else if (live) begin
        if (frame_end && !any_err) fl_q.done <= 1'b1;
        if (err_crc)   fl_q.crc   <= 1'b1;
        if (err_align) fl_q.align <= 1'b1;
        if (err_abort) fl_q.abort <= 1'b1;
      end
      if (overrun_evt)  fl_q.ovr <= 1'b1;
      else if (ovr_clr) fl_q.ovr <= 1'b0;
    end
  end

  assign rx_en  = en_q;
  assign ack_en = ack_q;
  assign flags  = fl_q;
endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rxf_pkg::*;
#(
  parameter int unsigned W     = BYTE_W,
  parameter int unsigned DEPTH = N_SLOTS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  input  logic         cfg_wr,
  input  logic         cfg_rx_en,
  input  logic         cfg_ack_en,
  input  logic         ovr_clr,
  input  logic         frame_end,
  input  logic         err_crc,
  input  logic         err_align,
  input  logic         err_abort,
  output logic         st_rx_en,
  output logic         st_ack_en,
  output logic         st_done,
  output logic         st_crc,
  output logic         st_align,
  output logic         st_abort,
  output logic         st_ovr
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          flush, pop, push, push_try, overrun_evt;
  logic          full, empty, ne_q, rx_en;
  logic [CW-1:0] count;
  rx_flags_t     flags;

  assign flush       = cfg_wr && cfg_rx_en;
  assign pop         = out_ready && ne_q && !empty && !flush;
  assign push_try    = in_valid && rx_en && !cfg_wr;
  assign push        = push_try && (!full || pop);
  assign overrun_evt = push_try && full && !pop;

  rxf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (in_data),
    .rdata (out_data),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ne_q <= 1'b0;
    else        ne_q <= (count != '0);
  end

  rxf_status u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_rx_en   (cfg_rx_en),
    .cfg_ack_en  (cfg_ack_en),
    .ovr_clr     (ovr_clr),
    .frame_end   (frame_end),
    .err_crc     (err_crc),
    .err_align   (err_align),
    .err_abort   (err_abort),
    .overrun_evt (overrun_evt),
    .rx_en       (rx_en),
    .ack_en      (st_ack_en),
    .flags       (flags)
  );

  assign in_ready  = rx_en && !full;
  assign out_valid = ne_q;
  assign st_rx_en  = rx_en;
  assign st_done   = flags.done;
  assign st_crc    = flags.crc;
  assign st_align  = flags.align;
  assign st_abort  = flags.abort;
  assign st_ovr    = flags.ovr;
endmodule

// File: rtl/rx_fifo_stat_checker.sv
module rx_fifo_stat_checker (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic out_valid,
  input logic cfg_wr,
  input logic cfg_rx_en,
  input logic cfg_ack_en,
  input logic ovr_clr,
  input logic frame_end,
  input logic err_crc,
  input logic err_align,
  input logic err_abort,
  input logic st_rx_en,
  input logic st_ack_en,
  input logic st_done,
  input logic st_crc,
  input logic st_align,
  input logic st_abort,
  input logic st_ovr
);
  AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> st_rx_en); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rx_en) |=> (st_rx_en && !st_done && !st_crc && !st_align && !st_abort)); // R4
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_rx_en) |=> ##1 !out_valid); // R4
  AST_STOP_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rx_en && !cfg_wr && (frame_end || err_crc || err_align || err_abort)) |=> !st_rx_en); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !ovr_clr) |=> st_ovr); // R6
  AST_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(st_ack_en)); // R10
  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && frame_end && (err_crc || err_align || err_abort) && !st_done) |=> !st_done); // R8
endmodule

bind rx_fifo_stat rx_fifo_stat_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .cfg_wr     (cfg_wr),
  .cfg_rx_en  (cfg_rx_en),
  .cfg_ack_en (cfg_ack_en),
  .ovr_clr    (ovr_clr),
  .frame_end  (frame_end),
  .err_crc    (err_crc),
  .err_align  (err_align),
  .err_abort  (err_abort),
  .st_rx_en   (st_rx_en),
  .st_ack_en  (st_ack_en),
  .st_done    (st_done),
  .st_crc     (st_crc),
  .st_align   (st_align),
  .st_abort   (st_abort),
  .st_ovr     (st_ovr)
);

// File: tb/rx_fifo_stat_tb.sv
module rx_fifo_stat_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, out_ready = 0, cfg_wr = 0, cfg_rx_en = 0, cfg_ack_en = 0;
  logic ovr_clr = 0, frame_end = 0, err_crc = 0, err_align = 0, err_abort = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic [7:0] out_data;
  logic st_rx_en, st_ack_en, st_done, st_crc, st_align, st_abort, st_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_stat u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .cfg_wr(cfg_wr), .cfg_rx_en(cfg_rx_en), .cfg_ack_en(cfg_ack_en), .ovr_clr(ovr_clr),
    .frame_end(frame_end), .err_crc(err_crc), .err_align(err_align), .err_abort(err_abort),
    .st_rx_en(st_rx_en), .st_ack_en(st_ack_en), .st_done(st_done), .st_crc(st_crc),
    .st_align(st_align), .st_abort(st_abort), .st_ovr(st_ovr)
  );

  // reference model state
  byte unsigned q[$];
  bit m_ne, m_en, m_ack, m_done, m_crc, m_al, m_ab, m_ovr;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 out_valid", out_valid, m_ne);
    chk("R5 in_ready", in_ready, (m_en && q.size() < 3));
    chk("R9 st_rx_en", st_rx_en, m_en);
    chk("R10 st_ack_en", st_ack_en, m_ack);
    chk("R8 st_done", st_done, m_done);
    chk("R8 st_crc", st_crc, m_crc);
    chk("R8 st_align", st_align, m_al);
    chk("R8 st_abort", st_abort, m_ab);
    chk("R6 st_ovr", st_ovr, m_ovr);
    if (q.size() > 0) chk("R1 out_data", out_data, q[0]);
  endtask

  // one edge of the reference model, from the requirements
  task automatic model_step();
    int old_sz = q.size();
    bit pop = out_ready && m_ne && (old_sz > 0);
    bit ovr_evt = 0;
    if (cfg_wr) begin
      m_en = cfg_rx_en; m_ack = cfg_ack_en;                  // R4 R10 R11
      if (cfg_rx_en) begin
        q.delete(); m_done = 0; m_crc = 0; m_al = 0; m_ab = 0;
      end else if (pop) void'(q.pop_front());
    end else begin
      if (pop) void'(q.pop_front());                        // R3
      if (m_en) begin
        if (in_valid) begin
          if (q.size() < 3) q.push_back(in_data);           // R7
          else ovr_evt = 1;                                 // R6
        end
        if (err_crc) m_crc = 1;
        if (err_align) m_al = 1;
        if (err_abort) m_ab = 1;
        if (frame_end && !err_crc && !err_align && !err_abort && !ovr_evt) m_done = 1;
        if (frame_end || err_crc || err_align || err_abort || ovr_evt) m_en = 0;
      end
    end
    if (ovr_evt) m_ovr = 1; else if (ovr_clr) m_ovr = 0;
    m_ne = (old_sz != 0);                                   // R2
  endtask

  task automatic idle_inputs();
    in_valid = 0; out_ready = 0; cfg_wr = 0; cfg_rx_en = 0; cfg_ack_en = 0;
    ovr_clr = 0; frame_end = 0; err_crc = 0; err_align = 0; err_abort = 0;
  endtask

  // inputs already set after a negedge; clock one edge and compare
  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic push_b(byte unsigned d);
    in_valid = 1; in_data = d; cycle();
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk);
    compare_all();                       // R12 reset state
    rst_n = 1;
    @(negedge clk);
    compare_all();

    // enable with ack bit
    cfg_wr = 1; cfg_rx_en = 1; cfg_ack_en = 1; cycle();
    // R1 fill three, R6 overrun on fourth
    push_b(8'h11); push_b(8'h22); push_b(8'h33);
    push_b(8'h44);
    cycle();
    // reads: oldest first; R3 stale-cycle read
    for (int i = 0; i < 5; i++) begin out_ready = 1; cycle(); end
    // R6 ovr stays across enable, R4
    cfg_wr = 1; cfg_rx_en = 1; cfg_ack_en = 0; cycle();
    chk("R6 ovr sticky over enable", st_ovr, 1);
    ovr_clr = 1; cycle();
    push_b(8'hA1); push_b(8'hA2); push_b(8'hA3);
    cycle();
    // R7 push with read on full
    in_valid = 1; in_data = 8'hA4; out_ready = 1; cycle();
    chk("R7 no overrun on read-first", st_ovr, 0);
    // R8 clean frame end
    frame_end = 1; cycle();
    chk("R8 done after clean end", st_done, 1);
    // R4 enable clears done and empties
    cfg_wr = 1; cfg_rx_en = 1; cycle();
    cycle();
    // R8 error with frame end: no done
    err_crc = 1; frame_end = 1; cycle();
    // R11 events ignored during control write
    cfg_wr = 1; cfg_rx_en = 1; in_valid = 1; in_data = 8'h5A; err_abort = 1; cycle();
    cycle();

    for (int c = 0; c < RAND_CYCLES; c++) begin
      in_valid   = ($urandom_range(0, 99) < 55);
      in_data    = 8'($urandom);
      out_ready  = ($urandom_range(0, 99) < 40);
      cfg_wr     = ($urandom_range(0, 99) < 4);
      cfg_rx_en  = ($urandom_range(0, 99) < 80);
      cfg_ack_en = $urandom_range(0, 1);
      ovr_clr    = ($urandom_range(0, 99) < 4);
      frame_end  = ($urandom_range(0, 99) < 3);
      err_crc    = ($urandom_range(0, 99) < 1);
      err_align  = ($urandom_range(0, 99) < 1);
      err_abort  = ($urandom_range(0, 99) < 1);
      cycle();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule